// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block lets a processor read a one-time-programmable fuse array of 8K bits through a small register window. The array is split into two 4K-bit halves. A control bit picks the half and a 9-bit byte address picks the location within it. Software first writes the timing configuration, then writes the control word with the read-enable bit set. The block then walks up to 32 consecutive byte addresses. For each byte it holds the address for a programmable setup time, then pulses the read strobe for a programmable width, and captures the byte returned by the array.

The captured bytes are packed little-endian into eight 32-bit buffer words. When the last byte has been stored, a done flag is raised, the read-enable bit drops back to zero, and an interrupt output follows the done flag when interrupts are enabled. The bits for the write path and the programming path can be set and read back, but they never move the fuse interface. While a read is in flight, the control and configuration registers cannot be written, so the timing and addressing stay fixed for the whole burst.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the control, configuration and status registers, all buffer words, `irq` and `fz_strobe` are 0.
- R2: The register at word index `bus_addr` is selected as follows. Index 0 is control and index 1 is configuration. Index 2 is status: bit 0 is read done and bit 1 is write done. Indices 3 to 10 are buffer words 0 to 7. Control reads back read-enable in bit 0, write-enable in bit 1, program-enable in bit 15, the length minus one in bits 20:16, the byte address in bits 29:21 and the half select in bit 30. Configuration reads back interrupt-enable in bit 31, the setup count in bits 23:20, the strobe count in bits 19:16, a write setup count in bits 15:12 and a write strobe count in bits 11:0. All other bits read 0, and writes to the status or buffer indices change nothing.
- R3: Before each strobe pulse, `fz_strobe` stays low for setup+1 clocks with the address applied. The pulse then stays high for strobe+4 clocks. One byte therefore takes setup+5+strobe clocks.
- R4: A read of N bytes (N = length field + 1) produces exactly N strobe pulses. Byte k is fetched from address (base + k) mod 512, and `fz_cs` equals control bit 30.
- R5: Byte k of the burst lands in buffer word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4). Buffer bytes at positions N and above read 0.
- R6: Writing control with bit 0 set while idle starts a read and clears read done. Read done becomes 1 exactly N*(setup+5+strobe) clocks after the clock edge that accepted the write. At that point control bit 0 reads 0. Read done is cleared only by the start of a new read.
- R7: `irq` is 1 exactly when configuration bit 31 and read done are both 1.
- R8: Writes to control or configuration while a read is in progress are ignored and do not disturb the running burst.
- R9: Write-enable and program-enable are stored and read back only. Setting them never pulses `fz_strobe`, and write done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write qualifier for a selected access |
| bus_addr | input | 6 | Register word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Read-complete interrupt |
| fz_cs | output | 1 | Fuse half select (1 = upper 4K bits) |
| fz_addr | output | 9 | Fuse byte address within the half |
| fz_strobe | output | 1 | Fuse read strobe |
| fz_rdata | input | 8 | Byte returned by the fuse array |

## Verification
Some properties are checked on every cycle. The setup phase before each strobe rise and the high time of each strobe are compared against the configured counts. The fuse address must hold steady while the strobe is high, and the half select must hold steady through a burst. The done flag and the interrupt must never be seen while the sequencer is busy. Other behaviour can only be shown by the bench's scenarios. These cover the exact completion latency, the byte order and zero fill in the buffer, address wrap-around, and the number of strobe pulses. They also cover the register writes that must be ignored while busy, and the write and program bits that must cause no fuse activity. The bench sweeps setup and strobe counts, every length from 1 to 32, and both halves.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;

    // Register word indices on the bus
    localparam logic [5:0] IDX_CTRL  = 6'd0;
    localparam logic [5:0] IDX_CFG   = 6'd1;
    localparam logic [5:0] IDX_STAT  = 6'd2;
    localparam logic [5:0] IDX_DATA0 = 6'd3;

    // Control word bit positions that do not depend on parameters
    localparam int C_RD_BIT  = 0;
    localparam int C_WR_BIT  = 1;
    localparam int C_PG_BIT  = 15;
    localparam int C_LEN_LSB = 16;

    // Timing field widths
    localparam int ADJ_W  = 4;
    localparam int STR_W  = 4;
    localparam int WADJ_W = 4;
    localparam int WSTR_W = 12;
    localparam int CNT_W  = $clog2((1 << STR_W) + 4);

    typedef struct packed {
        logic              irq_en;
        logic [ADJ_W-1:0]  rd_adj;
        logic [STR_W-1:0]  rd_str;
        logic [WADJ_W-1:0] wr_adj;
        logic [WSTR_W-1:0] wr_str;
    } cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE
    } sq_state_e;

    function automatic logic [31:0] cfg_word(cfg_t c);
        return {c.irq_en, 7'b0, c.rd_adj, c.rd_str, c.wr_adj, c.wr_str};
    endfunction

endpackage

// File: rtl/fuse_rd_regs.sv
`timescale 1ns/1ps
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_AW   = 9,
    parameter int BUF_WORDS = 8,
    parameter int IDX_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [5:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [BUF_WORDS*32-1:0] buf_words,
    input  logic                   busy,
    input  logic                   rd_finish,
    output logic                   start,
    output logic                   rd_done,
    output logic                   irq_en,
    output logic [ADJ_W-1:0]       rd_adj,
    output logic [STR_W-1:0]       rd_str,
    output logic [FUSE_AW-1:0]     rd_base,
    output logic [IDX_W-1:0]       rd_len_m1,
    output logic                   rd_cs
);
    localparam int C_ADDR_LSB = C_LEN_LSB + IDX_W;
    localparam int C_CS_BIT   = C_ADDR_LSB + FUSE_AW;
    localparam int WSEL_W     = $clog2(BUF_WORDS);

    logic rd_en_q, wr_en_q, pg_en_q;
    cfg_t cfg_q;
    logic wr_hit, wr_ctrl, wr_cfg;
    logic [5:0] didx;
    logic [31:0] ctrl_word;
    logic [31:0] word_arr [BUF_WORDS];

    assign wr_hit  = bus_sel && bus_wr && !busy;
    assign wr_ctrl = wr_hit && (bus_addr == IDX_CTRL);
    assign wr_cfg  = wr_hit && (bus_addr == IDX_CFG);
    assign start   = wr_ctrl && bus_wdata[C_RD_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en_q   <= 1'b0;
            wr_en_q   <= 1'b0;
            pg_en_q   <= 1'b0;
            rd_len_m1 <= '0;
            rd_base   <= '0;
            rd_cs     <= 1'b0;
        end else if (wr_ctrl) begin
            rd_en_q   <= bus_wdata[C_RD_BIT];
            wr_en_q   <= bus_wdata[C_WR_BIT];
            pg_en_q   <= bus_wdata[C_PG_BIT];
            rd_len_m1 <= bus_wdata[C_LEN_LSB +: IDX_W];
            rd_base   <= bus_wdata[C_ADDR_LSB +: FUSE_AW];
            rd_cs     <= bus_wdata[C_CS_BIT];
        end else if (rd_finish) begin
            rd_en_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.irq_en <= bus_wdata[31];
            cfg_q.rd_adj <= bus_wdata[20 +: ADJ_W];
            cfg_q.rd_str <= bus_wdata[16 +: STR_W];
            cfg_q.wr_adj <= bus_wdata[12 +: WADJ_W];
            cfg_q.wr_str <= bus_wdata[0 +: WSTR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            rd_done <= 1'b0;
        else if (start)     rd_done <= 1'b0;
        else if (rd_finish) rd_done <= 1'b1;
    end

    assign irq_en = cfg_q.irq_en;
    assign rd_adj = cfg_q.rd_adj;
    assign rd_str = cfg_q.rd_str;

    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[C_RD_BIT]                = rd_en_q;
        ctrl_word[C_WR_BIT]                = wr_en_q;
        ctrl_word[C_PG_BIT]                = pg_en_q;
        ctrl_word[C_LEN_LSB +: IDX_W]      = rd_len_m1;
        ctrl_word[C_ADDR_LSB +: FUSE_AW]   = rd_base;
        ctrl_word[C_CS_BIT]                = rd_cs;
    end

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        assign word_arr[w] = buf_words[w*32 +: 32];
    end

    assign didx = bus_addr - IDX_DATA0;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == IDX_CTRL)
            bus_rdata = ctrl_word;
        else if (bus_addr == IDX_CFG)
            bus_rdata = cfg_word(cfg_q);
        else if (bus_addr == IDX_STAT)
            bus_rdata = {30'b0, 1'b0, rd_done};
        else if (bus_addr >= IDX_DATA0 && didx < 6'(BUF_WORDS))
            bus_rdata = word_arr[didx[WSEL_W-1:0]];
    end

endmodule

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_AW = 9,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FUSE_AW-1:0] rd_base,
    input  logic [IDX_W-1:0]   rd_len_m1,
    input  logic               rd_cs,
    input  logic [ADJ_W-1:0]   rd_adj,
    input  logic [STR_W-1:0]   rd_str,
    input  logic [7:0]         fz_rdata,
    output logic               fz_cs,
    output logic [FUSE_AW-1:0] fz_addr,
    output logic               fz_strobe,
    output logic               busy,
    output logic               byte_vld,
    output logic [IDX_W-1:0]   byte_idx,
    output logic [7:0]         byte_data,
    output logic               rd_finish
);
    sq_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               setup_last, strobe_last, last_byte;

    assign setup_last  = (cnt == CNT_W'(rd_adj));
    assign strobe_last = (cnt == CNT_W'(rd_str) + CNT_W'(3));
    assign last_byte   = (idx == rd_len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_SETUP;
                        cnt   <= '0;
                        idx   <= '0;
                    end
                end
                SQ_SETUP: begin
                    if (setup_last) begin
                        state <= SQ_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                SQ_STROBE: begin
                    if (strobe_last) begin
                        cnt <= '0;
                        if (last_byte) begin
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_SETUP;
                            idx   <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state != SQ_IDLE);
    assign fz_strobe = (state == SQ_STROBE);
    assign fz_cs     = rd_cs;
    assign fz_addr   = rd_base + FUSE_AW'(idx);
    assign byte_vld  = fz_strobe && strobe_last;
    assign byte_idx  = idx;
    assign byte_data = fz_rdata;
    assign rd_finish = byte_vld && last_byte;

endmodule

// File: rtl/fuse_rd_buf.sv
`timescale 1ns/1ps
module fuse_rd_buf #(
    parameter int BUF_WORDS = 8,
    parameter int IDX_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    output logic [BUF_WORDS*32-1:0] words
);
    localparam int NBYTES = BUF_WORDS * 4;

    logic [7:0] mem [NBYTES];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_w
        for (genvar b = 0; b < 4; b++) begin : g_b
            assign words[w*32 + b*8 +: 8] = mem[w*4 + b];
        end
    end

endmodule

// File: rtl/fuse_rd_ctrl.sv
`timescale 1ns/1ps
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_AW   = 9,
    parameter int BUF_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [5:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               fz_cs,
    output logic [FUSE_AW-1:0] fz_addr,
    output logic               fz_strobe,
    input  logic [7:0]         fz_rdata
);
    localparam int IDX_W = $clog2(BUF_WORDS * 4);

    logic                    start, rd_done, irq_en;
    logic                    seq_busy, rd_finish, byte_vld;
    logic [ADJ_W-1:0]        cfg_adj;
    logic [STR_W-1:0]        cfg_str;
    logic [FUSE_AW-1:0]      rd_base;
    logic [IDX_W-1:0]        rd_len_m1, byte_idx;
    logic                    rd_cs;
    logic [7:0]              byte_data;
    logic [BUF_WORDS*32-1:0] buf_words;

    fuse_rd_regs #(
        .FUSE_AW  (FUSE_AW),
        .BUF_WORDS(BUF_WORDS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .buf_words(buf_words),
        .busy     (seq_busy),
        .rd_finish(rd_finish),
        .start    (start),
        .rd_done  (rd_done),
        .irq_en   (irq_en),
        .rd_adj   (cfg_adj),
        .rd_str   (cfg_str),
        .rd_base  (rd_base),
        .rd_len_m1(rd_len_m1),
        .rd_cs    (rd_cs)
    );

    fuse_rd_seq #(
        .FUSE_AW(FUSE_AW),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_base  (rd_base),
        .rd_len_m1(rd_len_m1),
        .rd_cs    (rd_cs),
        .rd_adj   (cfg_adj),
        .rd_str   (cfg_str),
        .fz_rdata (fz_rdata),
        .fz_cs    (fz_cs),
        .fz_addr  (fz_addr),
        .fz_strobe(fz_strobe),
        .busy     (seq_busy),
        .byte_vld (byte_vld),
        .byte_idx (byte_idx),
        .byte_data(byte_data),
        .rd_finish(rd_finish)
    );

    fuse_rd_buf #(
        .BUF_WORDS(BUF_WORDS),
        .IDX_W    (IDX_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .wr_en  (byte_vld),
        .wr_idx (byte_idx),
        .wr_data(byte_data),
        .words  (buf_words)
    );

    assign irq = irq_en && rd_done;

endmodule

// File: rtl/fuse_rd_chk.sv
`timescale 1ns/1ps
module fuse_rd_chk
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_AW = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               fz_cs,
    input logic [FUSE_AW-1:0] fz_addr,
    input logic               fz_strobe,
    input logic               irq,
    input logic               busy,
    input logic               rd_done,
    input logic [ADJ_W-1:0]   rd_adj,
    input logic [STR_W-1:0]   rd_str
);
    logic [5:0] lo_cnt, hi_cnt;
    logic       prev_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            prev_s <= 1'b0;
        end else begin
            prev_s <= fz_strobe;
            lo_cnt <= (!busy || fz_strobe) ? 6'd0 : lo_cnt + 6'd1;
            hi_cnt <= fz_strobe ? hi_cnt + 6'd1 : 6'd0;
            // R3: setup phase length measured at each strobe rise
            if (fz_strobe && !prev_s)
                p_setup_len_r3: assert (lo_cnt == 6'(rd_adj) + 6'd1);
            // R3: strobe high time measured at each strobe fall
            if (!fz_strobe && prev_s)
                p_strobe_len_r3: assert (hi_cnt == 6'(rd_str) + 6'd4);
        end
    end

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (fz_strobe && $past(fz_strobe)) |-> $stable(fz_addr));

    p_cs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fz_cs));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !busy);

    p_irq_idle_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy);

endmodule

bind fuse_rd_ctrl fuse_rd_chk #(.FUSE_AW(FUSE_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fz_cs    (fz_cs),
    .fz_addr  (fz_addr),
    .fz_strobe(fz_strobe),
    .irq      (irq),
    .busy     (seq_busy),
    .rd_done  (rd_done),
    .rd_adj   (cfg_adj),
    .rd_str   (cfg_str)
);

// File: tb/fuse_rd_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, fz_cs, fz_strobe;
    logic [8:0]  fz_addr;
    logic [7:0]  fz_rdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc_ctr = 0;
    int pulses = 0;
    int last_wr_cyc = 0;
    logic prev_s = 1'b0;

    // expected parameters of the current read
    logic       e_cs, e_ie;
    logic [8:0] e_base;
    int         e_n, e_adj, e_str, c0, p0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom(input logic [9:0] i);
        logic [15:0] t;
        t = 16'(i) * 16'd29 + 16'd7;
        return t[7:0] ^ t[15:8] ^ (i[9] ? 8'hA5 : 8'h00);
    endfunction

    assign fz_rdata = rom({fz_cs, fz_addr});

    fuse_rd_ctrl u_fuse_rd_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .fz_cs(fz_cs), .fz_addr(fz_addr), .fz_strobe(fz_strobe),
        .fz_rdata(fz_rdata)
    );

    always @(posedge clk) begin
        cyc_ctr <= cyc_ctr + 1;
        prev_s  <= fz_strobe;
        if (fz_strobe && !prev_s) pulses <= pulses + 1;
    end

    function automatic logic [31:0] exp_word(input logic cs, input logic [8:0] base,
                                             input int n, input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int k = 4*w + b;
            if (k < n) r[8*b +: 8] = rom({cs, 9'(int'(base) + k)});
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        last_wr_cyc = cyc_ctr;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_val(input logic cs, input logic [8:0] base,
                                             input int n, input logic rd_en);
        return {1'b0, cs, base, 5'(n - 1), 1'b0, 13'b0, 1'b0, rd_en};
    endfunction

    function automatic logic [31:0] cfg_val(input logic ie, input int adj, input int str);
        return {ie, 7'b0, 4'(adj), 4'(str), 16'h0};
    endfunction

    task automatic start_read(input logic cs, input logic [8:0] base, input int n,
                              input int adj, input int str, input logic ie);
        logic [31:0] d;
        e_cs = cs; e_base = base; e_n = n; e_adj = adj; e_str = str; e_ie = ie;
        wr(6'd1, cfg_val(ie, adj, str));
        p0 = pulses;
        wr(6'd0, ctrl_val(cs, base, n, 1'b1));
        c0 = last_wr_cyc;
        chk("R7 irq low after start", {31'b0, irq}, 32'h0);
        rd(6'd2, d);
        chk("R6 done cleared by start", d, 32'h0);
    endtask

    task automatic finish_read();
        logic [31:0] d;
        int cycles = -1;
        for (int g = 0; g < 5000; g++) begin
            rd(6'd2, d);
            if (d[0]) begin
                cycles = cyc_ctr - c0;
                break;
            end
            @(negedge clk);
        end
        chk("R6 completion latency", cycles, e_n * (e_adj + 5 + e_str));
        chk("R4 strobe pulse count", pulses - p0, e_n);
        chk("R6 status after read", d, 32'h1);
        rd(6'd0, d);
        chk("R6 read enable cleared", d, ctrl_val(e_cs, e_base, e_n, 1'b0));
        chk("R7 irq after read", {31'b0, irq}, {31'b0, e_ie});
        for (int w = 0; w < 8; w++) begin
            rd(6'(3 + w), d);
            chk("R5 buffer word", d, exp_word(e_cs, e_base, e_n, w));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int adjs[4] = '{0, 3, 7, 15};
        int strs[4] = '{0, 4, 9, 15};
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(6'd0, d); chk("R1 control", d, 32'h0);
        rd(6'd1, d); chk("R1 config", d, 32'h0);
        rd(6'd2, d); chk("R1 status", d, 32'h0);
        rd(6'd3, d); chk("R1 buffer word 0", d, 32'h0);
        rd(6'd10, d); chk("R1 buffer word 7", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 strobe", {31'b0, fz_strobe}, 32'h0);

        // R2 field positions, R9 write/program bits cause no activity
        wr(6'd1, 32'hFFFF_FFFF);
        rd(6'd1, d); chk("R2 config readback", d, 32'h80FF_FFFF);
        p0 = pulses;
        wr(6'd0, 32'hFFFF_FFFE);
        rd(6'd0, d); chk("R2 control readback", d, 32'h7FFF_8002);
        repeat (40) @(negedge clk);
        chk("R9 no strobe for write/program bits", pulses - p0, 0);
        rd(6'd2, d); chk("R9 write done stays 0", d, 32'h0);
        wr(6'd1, 32'h0);
        wr(6'd0, 32'h0);
        wr(6'd3, 32'hFFFF_FFFF);
        rd(6'd3, d); chk("R2 buffer write ignored", d, 32'h0);
        wr(6'd2, 32'hFFFF_FFFF);
        rd(6'd2, d); chk("R2 status write ignored", d, 32'h0);

        // R3: sweep of setup and strobe counts
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 4; s++) begin
                start_read(adjs[a][0], 9'(64 + 16*a + s), 3, adjs[a], strs[s], 1'b0);
                finish_read();
            end
        end

        // R5: every length 1..32, both halves
        for (int n = 1; n <= 32; n++) begin
            start_read(n[0], 9'(n * 13), n, 1, 0, 1'b0);
            finish_read();
        end

        // R4: address wrap within the upper half
        start_read(1'b1, 9'h1F0, 32, 2, 1, 1'b0);
        finish_read();

        // R7: interrupt follows done when enabled
        start_read(1'b0, 9'h0A0, 4, 0, 2, 1'b1);
        finish_read();
        wr(6'd1, cfg_val(1'b0, 0, 2));
        chk("R7 irq drops with enable", {31'b0, irq}, 32'h0);
        wr(6'd1, cfg_val(1'b1, 0, 2));
        chk("R7 irq returns with enable", {31'b0, irq}, 32'h1);

        // R8: writes during a read are ignored
        start_read(1'b0, 9'h100, 32, 15, 15, 1'b0);
        repeat (100) @(negedge clk);
        wr(6'd1, 32'h8000_0000);
        wr(6'd0, 32'h40AB_8003);
        finish_read();
        rd(6'd1, d); chk("R8 config unchanged", d, cfg_val(1'b0, 15, 15));

        // R9: write/program bits after a completed read
        p0 = pulses;
        wr(6'd0, 32'h0000_8002);
        repeat (40) @(negedge clk);
        chk("R9 no strobe after read", pulses - p0, 0);
        rd(6'd2, d); chk("R9 status keeps done, write done 0", d, 32'h1);
        rd(6'd0, d); chk("R9 control readback", d, 32'h0000_8002);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule